// File: doc/BRIEF.md
# Descriptor Table Base Pointer Bank

This block holds the memory base addresses of the buffer-descriptor tables used by a DMA memory access layer. There is one pointer for each transmit channel and one for each receive channel. Every pointer drives a parallel output that feeds the descriptor fetch logic. Software loads the pointers through a simple write port and reads them back through a combinational read port.

The most significant bits of all pointers of one direction sit in a single physical register. Writing any transmit pointer therefore moves the upper address bits of every transmit pointer, and the receive side works the same way. The bits below the shared field are stored per channel. The lowest bits are always zero, which keeps each table doubleword aligned. Pointers survive soft resets and channel resets, and only the hard reset clears them.

A transmit pointer may change only while no transmit channel is active. If a write arrives while a channel is active, the block drops the write and raises a sticky error flag. Software clears that flag by writing a one to it.

Top module: `desc_base_bank`

## Requirements
- R1: A transmit write that is accepted loads wr_data[31:19] into the upper 13 bits of every transmit pointer, and loads wr_data[18:3] into bits [18:3] of the addressed transmit pointer only.
- R2: A receive write loads wr_data[31:19] into the shared upper bits of every receive pointer and wr_data[18:3] into the addressed receive pointer's bits [18:3].
- R3: Bits [2:0] of every pointer output and of every pointer read are always zero, whatever value was written.
- R4: A transmit write is dropped when any transmit channel is enabled (tx_en=1), not idle (tx_idle=0) and not held in channel reset. When that happens, all transmit pointers keep their values and wr_err is set. A channel held in channel reset counts as inactive.
- R5: wr_err stays set until a write to the status offset 0xC with wr_data[0]=1. Writing 0 in bit 0 leaves it set.
- R6: soft_rst, tx_chan_rst and rx_chan_rst leave every pointer unchanged. soft_rst also clears wr_err.
- R7: The hard reset (rst_n=0) clears all pointers and wr_err.
- R8: The register map is: transmit channel i at offset 4*i (0x0, 0x4); receive channel j at 4*(2+j) (0x8); status at 0xC, with wr_err in bit 0. Any other offset, including one with nonzero bits [1:0], reads zero and ignores writes. Reads have no side effect.
- R9: A write becomes visible on the pointer outputs at the first rising clock edge on which wr_en is sampled high, and not before that edge.
- R10: Receive writes are accepted whatever the transmit idle, enable and channel-reset inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset; keeps the pointers and clears the error flag |
| tx_chan_rst | input | 2 | Per-transmit-channel reset |
| rx_chan_rst | input | 1 | Per-receive-channel reset |
| tx_idle | input | 2 | Transmit channel reports idle |
| tx_en | input | 2 | Transmit channel enabled |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| tx_base | output | 64 | Transmit table bases, channel 0 in bits [31:0] |
| rx_base | output | 32 | Receive table base |
| wr_err | output | 1 | Sticky error flag for a dropped transmit write |

## Verification
The bench writes one transmit channel and then checks that the upper bits of the other transmit channel moved while its lower bits did not. A design with separate upper registers would leave the second channel untouched, and one with fully shared storage would overwrite its lower bits. It tries transmit writes while each channel in turn is busy, while a channel is disabled, and while a channel is held in channel reset. A wrong busy test would either corrupt a live pointer or drop a legal write. It also pulses soft and channel resets and reads misaligned and unmapped offsets. A design that cleared pointers on those resets, or that decoded only some of the address bits, would show changed values there.

// File: rtl/dbb_pkg.sv
package dbb_pkg;

   localparam int WORD_BYTES = 4;

   // Byte offset of the idx-th register word.
   function automatic int word_off(input int idx);
      return idx * WORD_BYTES;
   endfunction

   // Number of per-channel address bits between the shared field and the alignment zeros.
   function automatic int private_w(input int ptr_w, input int shared_w, input int align_w);
      return ptr_w - shared_w - align_w;
   endfunction

endpackage

// File: rtl/dbb_addr_dec.sv
module dbb_addr_dec
   import dbb_pkg::*;
#(
   parameter int N_TX  = 2,
   parameter int N_RX  = 1,
   parameter int OFF_W = 4
) (
   input  logic [OFF_W-1:0] addr,
   output logic [N_TX-1:0]  hit_tx,
   output logic [N_RX-1:0]  hit_rx,
   output logic             hit_stat
);

   for (genvar g = 0; g < N_TX; g++) begin : g_tx
      assign hit_tx[g] = (addr == OFF_W'(word_off(g)));
   end

   for (genvar g = 0; g < N_RX; g++) begin : g_rx
      assign hit_rx[g] = (addr == OFF_W'(word_off(N_TX + g)));
   end

   assign hit_stat = (addr == OFF_W'(word_off(N_TX + N_RX)));

endmodule

// File: rtl/dbb_dir_bank.sv
module dbb_dir_bank
   import dbb_pkg::*;
#(
   parameter int PTR_W    = 32,
   parameter int SHARED_W = 13,
   parameter int ALIGN_W  = 3,
   parameter int N_CH     = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_CH-1:0]         wr_sel,
   input  logic                    wr_ok,
   input  logic [PTR_W-1:ALIGN_W]  wr_val,
   output logic [N_CH*PTR_W-1:0]   base_o
);

   localparam int LOW_W = private_w(PTR_W, SHARED_W, ALIGN_W);

   logic [SHARED_W-1:0] upper_q;
   logic                take;

   assign take = wr_ok & (|wr_sel);

   // One physical copy of the upper field for the whole direction.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         upper_q <= '0;
      else if (take)
         upper_q <= wr_val[PTR_W-1 -: SHARED_W];
   end

   if (LOW_W > 0) begin : g_split
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         logic [LOW_W-1:0] low_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               low_q <= '0;
            else if (wr_ok && wr_sel[c])
               low_q <= wr_val[ALIGN_W +: LOW_W];
         end

         assign base_o[c*PTR_W +: PTR_W] = {upper_q, low_q, {ALIGN_W{1'b0}}};
      end
   end else begin : g_flat
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign base_o[c*PTR_W +: PTR_W] = {upper_q, {ALIGN_W{1'b0}}};
      end
   end

endmodule

// File: rtl/dbb_err_flag.sv
module dbb_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   // A new violation wins over a clear that arrives in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

endmodule

// File: rtl/desc_base_bank.sv
module desc_base_bank
   import dbb_pkg::*;
#(
   parameter int PTR_W    = 32,
   parameter int SHARED_W = 13,
   parameter int ALIGN_W  = 3,
   parameter int N_TX     = 2,
   parameter int N_RX     = 1,
   parameter int OFF_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic [N_TX-1:0]       tx_chan_rst,
   input  logic [N_RX-1:0]       rx_chan_rst,
   input  logic [N_TX-1:0]       tx_idle,
   input  logic [N_TX-1:0]       tx_en,
   input  logic                  wr_en,
   input  logic [OFF_W-1:0]      wr_addr,
   input  logic [PTR_W-1:0]      wr_data,
   input  logic [OFF_W-1:0]      rd_addr,
   output logic [PTR_W-1:0]      rd_data,
   output logic [N_TX*PTR_W-1:0] tx_base,
   output logic [N_RX*PTR_W-1:0] rx_base,
   output logic                  wr_err
);

   localparam int N_WORDS = N_TX + N_RX + 1;
   localparam int LOW_W   = private_w(PTR_W, SHARED_W, ALIGN_W);

   // Elaboration-time parameter checks
   if (LOW_W < 0) begin : g_bad_split
      $error("shared and alignment fields exceed the pointer width");
   end
   if (ALIGN_W < 1 || SHARED_W < 1) begin : g_bad_fields
      $error("shared and alignment fields must be at least one bit");
   end
   if (N_TX < 1 || N_RX < 1) begin : g_bad_count
      $error("each direction needs at least one channel");
   end
   if (word_off(N_WORDS) > (1 << OFF_W)) begin : g_bad_map
      $error("offset width too small for the register map");
   end

   logic [N_TX-1:0] w_tx, r_tx, tx_we;
   logic [N_RX-1:0] w_rx, r_rx, rx_we;
   logic            w_st, r_st;
   logic            tx_quiet;
   logic            err_set, err_clr;

   dbb_addr_dec #(.N_TX(N_TX), .N_RX(N_RX), .OFF_W(OFF_W)) u_wdec (
      .addr(wr_addr), .hit_tx(w_tx), .hit_rx(w_rx), .hit_stat(w_st)
   );

   dbb_addr_dec #(.N_TX(N_TX), .N_RX(N_RX), .OFF_W(OFF_W)) u_rdec (
      .addr(rd_addr), .hit_tx(r_tx), .hit_rx(r_rx), .hit_stat(r_st)
   );

   assign tx_we = w_tx & {N_TX{wr_en}};
   assign rx_we = w_rx & {N_RX{wr_en}};

   // A channel is inactive when idle, disabled or held in channel reset.
   assign tx_quiet = &(tx_idle | ~tx_en | tx_chan_rst);

   dbb_dir_bank #(.PTR_W(PTR_W), .SHARED_W(SHARED_W), .ALIGN_W(ALIGN_W), .N_CH(N_TX)) u_tx (
      .clk(clk), .rst_n(rst_n), .wr_sel(tx_we), .wr_ok(tx_quiet),
      .wr_val(wr_data[PTR_W-1:ALIGN_W]), .base_o(tx_base)
   );

   dbb_dir_bank #(.PTR_W(PTR_W), .SHARED_W(SHARED_W), .ALIGN_W(ALIGN_W), .N_CH(N_RX)) u_rx (
      .clk(clk), .rst_n(rst_n), .wr_sel(rx_we), .wr_ok(1'b1),
      .wr_val(wr_data[PTR_W-1:ALIGN_W]), .base_o(rx_base)
   );

   assign err_set = (|tx_we) & ~tx_quiet;
   assign err_clr = soft_rst | (wr_en & w_st & wr_data[0]);

   dbb_err_flag u_err (
      .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .flag_o(wr_err)
   );

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_TX; i++)
         if (r_tx[i]) rd_data = tx_base[i*PTR_W +: PTR_W];
      for (int j = 0; j < N_RX; j++)
         if (r_rx[j]) rd_data = rx_base[j*PTR_W +: PTR_W];
      if (r_st) rd_data = {{(PTR_W-1){1'b0}}, wr_err};
   end

   // Receive channel resets and the alignment data bits have no effect on storage.
   logic unused_sink;
   assign unused_sink = ^{rx_chan_rst, wr_data[ALIGN_W-1:0]};

endmodule

// File: rtl/desc_base_bank_chk.sv
module desc_base_bank_chk
   import dbb_pkg::*;
#(
   parameter int PTR_W    = 32,
   parameter int SHARED_W = 13,
   parameter int ALIGN_W  = 3,
   parameter int N_TX     = 2,
   parameter int N_RX     = 1,
   parameter int OFF_W    = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  soft_rst,
   input logic [N_TX-1:0]       tx_chan_rst,
   input logic [N_RX-1:0]       rx_chan_rst,
   input logic [N_TX-1:0]       tx_idle,
   input logic [N_TX-1:0]       tx_en,
   input logic                  wr_en,
   input logic [OFF_W-1:0]      wr_addr,
   input logic [PTR_W-1:0]      wr_data,
   input logic [OFF_W-1:0]      rd_addr,
   input logic [PTR_W-1:0]      rd_data,
   input logic [N_TX*PTR_W-1:0] tx_base,
   input logic [N_RX*PTR_W-1:0] rx_base,
   input logic                  wr_err
);

   localparam int ST_OFF = word_off(N_TX + N_RX);

   logic tx_hit, tx_quiet, rd_mapped;

   always_comb begin
      tx_hit = 1'b0;
      for (int i = 0; i < N_TX; i++)
         if (wr_addr == OFF_W'(word_off(i))) tx_hit = 1'b1;
      rd_mapped = 1'b0;
      for (int i = 0; i < N_TX + N_RX + 1; i++)
         if (rd_addr == OFF_W'(word_off(i))) rd_mapped = 1'b1;
   end

   assign tx_quiet = &(tx_idle | ~tx_en | tx_chan_rst);

   // R4: a write to a busy transmit side changes nothing and raises the flag
   a_r4_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && tx_hit && !tx_quiet |=> $stable(tx_base) && wr_err);

   // R5: the flag holds until soft reset or a write-one clear
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err && !soft_rst && !(wr_en && wr_addr == OFF_W'(ST_OFF) && wr_data[0]) |=> wr_err);

   // R6: soft and channel resets keep the pointers
   a_r6_retain: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst || (|tx_chan_rst) || (|rx_chan_rst)) && !wr_en
      |=> $stable(tx_base) && $stable(rx_base));

   // R9: nothing moves without a write strobe
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(tx_base) && $stable(rx_base));

   // R8: unmapped read offsets return zero
   a_r8_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mapped |-> rd_data == '0);

   // R1: an accepted transmit write sets the upper field of every transmit pointer
   for (genvar i = 0; i < N_TX; i++) begin : g_txa
      a_r1_shared: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && tx_hit && tx_quiet
         |=> tx_base[i*PTR_W + PTR_W-1 -: SHARED_W] == $past(wr_data[PTR_W-1 -: SHARED_W]));
   end

   // R2, R3, R10: a receive write loads the aligned value regardless of transmit state
   for (genvar j = 0; j < N_RX; j++) begin : g_rxa
      a_r2_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && wr_addr == OFF_W'(word_off(N_TX + j))
         |=> rx_base[j*PTR_W +: PTR_W] == {$past(wr_data[PTR_W-1:ALIGN_W]), {ALIGN_W{1'b0}}});
   end

endmodule

bind desc_base_bank desc_base_bank_chk #(
   .PTR_W(PTR_W), .SHARED_W(SHARED_W), .ALIGN_W(ALIGN_W),
   .N_TX(N_TX), .N_RX(N_RX), .OFF_W(OFF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_chan_rst(tx_chan_rst),
   .rx_chan_rst(rx_chan_rst), .tx_idle(tx_idle), .tx_en(tx_en), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .tx_base(tx_base), .rx_base(rx_base), .wr_err(wr_err)
);

// File: tb/test_desc_base_bank.sv
module test_desc_base_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [1:0]  tx_chan_rst = '0;
   logic [0:0]  rx_chan_rst = '0;
   logic [1:0]  tx_idle = 2'b11;
   logic [1:0]  tx_en = 2'b11;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [63:0] tx_base;
   logic [31:0] rx_base;
   logic        wr_err;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   desc_base_bank i_desc_base_bank (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_chan_rst(tx_chan_rst),
      .rx_chan_rst(rx_chan_rst), .tx_idle(tx_idle), .tx_en(tx_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_base(tx_base), .rx_base(rx_base), .wr_err(wr_err)
   );

   typedef struct packed {
      logic        wen;
      logic [3:0]  addr;
      logic [31:0] data;
      logic [1:0]  idle;
      logic [1:0]  en;
      logic [31:0] e_tx0;
      logic [31:0] e_tx1;
      logic [31:0] e_rx0;
      logic        e_err;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // R1 R3: tx0 write, upper shared into tx1
      '{1'b1, 4'h0, 32'hABCD_1237, 2'b11, 2'b11, 32'hABCD_1230, 32'hABC8_0000, 32'h0, 1'b0},
      // R1: tx1 write moves tx0 upper bits only
      '{1'b1, 4'h4, 32'h1234_5678, 2'b11, 2'b11, 32'h1235_1230, 32'h1234_5678, 32'h0, 1'b0},
      // R2 R10: rx write while tx busy
      '{1'b1, 4'h8, 32'hFFFF_FFFF, 2'b00, 2'b11, 32'h1235_1230, 32'h1234_5678, 32'hFFFF_FFF8, 1'b0},
      // R4: ch0 busy, write dropped, flag set
      '{1'b1, 4'h0, 32'h0000_0000, 2'b10, 2'b11, 32'h1235_1230, 32'h1234_5678, 32'hFFFF_FFF8, 1'b1},
      // R4: both disabled, write accepted
      '{1'b1, 4'h0, 32'h0000_0000, 2'b00, 2'b00, 32'h0000_0000, 32'h0004_5678, 32'hFFFF_FFF8, 1'b1},
      // R5: write-one clear
      '{1'b1, 4'hC, 32'h0000_0001, 2'b11, 2'b11, 32'h0000_0000, 32'h0004_5678, 32'hFFFF_FFF8, 1'b0},
      // R8: misaligned offset ignored
      '{1'b1, 4'h2, 32'hFFFF_FFFF, 2'b11, 2'b11, 32'h0000_0000, 32'h0004_5678, 32'hFFFF_FFF8, 1'b0},
      // R4: ch1 busy
      '{1'b1, 4'h4, 32'h8000_0007, 2'b01, 2'b11, 32'h0000_0000, 32'h0004_5678, 32'hFFFF_FFF8, 1'b1},
      // R4 R3: ch1 disabled, accepted
      '{1'b1, 4'h4, 32'h8000_0007, 2'b01, 2'b01, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFF8, 1'b1},
      // R2: rx low bits
      '{1'b1, 4'h8, 32'h0000_0010, 2'b11, 2'b11, 32'h8000_0000, 32'h8000_0000, 32'h0000_0010, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   task automatic do_write(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      chk("R7 reset tx", tx_base[31:0] | tx_base[63:32], 32'h0);
      chk("R7 reset rx", rx_base, 32'h0);
      chk("R7 reset err", {31'b0, wr_err}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         tx_idle = VECS[v].idle; tx_en = VECS[v].en;
         wr_en = VECS[v].wen; wr_addr = VECS[v].addr; wr_data = VECS[v].data;
         @(posedge clk);
         @(negedge clk);
         wr_en = 1'b0;
         chk($sformatf("vec%0d tx0 R1/R4", v), tx_base[31:0], VECS[v].e_tx0);
         chk($sformatf("vec%0d tx1 R1/R4", v), tx_base[63:32], VECS[v].e_tx1);
         chk($sformatf("vec%0d rx0 R2", v), rx_base, VECS[v].e_rx0);
         chk($sformatf("vec%0d err R5", v), {31'b0, wr_err}, {31'b0, VECS[v].e_err});
      end
      tx_idle = 2'b11; tx_en = 2'b11;

      // R8: read map and unmapped offsets
      rd_addr = 4'h0; #1 chk("R8 read tx0", rd_data, 32'h8000_0000);
      rd_addr = 4'h8; #1 chk("R8 read rx0", rd_data, 32'h0000_0010);
      rd_addr = 4'hC; #1 chk("R8 read status", rd_data, 32'h0000_0001);
      rd_addr = 4'h2; #1 chk("R8 read misaligned", rd_data, 32'h0);
      rd_addr = 4'hE; #1 chk("R8 read unmapped", rd_data, 32'h0);
      @(negedge clk);
      chk("R8 read no side effect", tx_base[31:0] ^ tx_base[63:32] ^ rx_base, 32'h0000_0010);

      // R6: soft reset keeps pointers, clears flag
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk("R6 soft keep tx1", tx_base[63:32], 32'h8000_0000);
      chk("R6 soft keep rx0", rx_base, 32'h0000_0010);
      chk("R6 soft clears err", {31'b0, wr_err}, 32'h0);

      // R6: channel resets keep pointers
      tx_chan_rst = 2'b11; rx_chan_rst = 1'b1; tx_idle = 2'b00; tx_en = 2'b11;
      @(negedge clk);
      chk("R6 chan keep tx0", tx_base[31:0], 32'h8000_0000);
      chk("R6 chan keep rx0", rx_base, 32'h0000_0010);

      // R4: busy channels held in channel reset count as inactive
      do_write(4'h0, 32'h0000_1000);
      chk("R4 chan-reset allows tx0", tx_base[31:0], 32'h0000_1000);
      chk("R4 chan-reset allows tx1 upper", tx_base[63:32], 32'h0000_0000);
      chk("R4 chan-reset no err", {31'b0, wr_err}, 32'h0);
      tx_chan_rst = 2'b00; rx_chan_rst = 1'b0;

      // R5: writing zero does not clear; writing one does
      do_write(4'h4, 32'hFFFF_FFFF);
      chk("R4 busy drop tx1", tx_base[63:32], 32'h0000_0000);
      chk("R4 busy sets err", {31'b0, wr_err}, 32'h1);
      do_write(4'hC, 32'hFFFF_FFFE);
      chk("R5 write zero keeps err", {31'b0, wr_err}, 32'h1);
      do_write(4'hC, 32'h0000_0001);
      chk("R5 write one clears err", {31'b0, wr_err}, 32'h0);
      tx_idle = 2'b11;

      // R9: visible only after the sampling edge
      wr_en = 1'b1; wr_addr = 4'h8; wr_data = 32'h0000_0100;
      @(posedge clk);
      #1 ;
      chk("R9 updated after edge", rx_base, 32'h0000_0100);
      @(negedge clk);
      wr_en = 1'b0;
      wr_addr = 4'h8; wr_data = 32'h0000_0200;
      #1 chk("R9 no change before strobe", rx_base, 32'h0000_0100);

      // R7: hard reset clears everything
      do_write(4'h4, 32'h0000_0009);
      do_write(4'h0, 32'hFFFF_0000);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R7 hard tx", tx_base[31:0] | tx_base[63:32], 32'h0);
      chk("R7 hard rx", rx_base, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      report();
      $finish;
   end

endmodule